// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit sits next to the program counter of a 32-bit RISC core and turns faults, traps and external interrupt requests into a forced procedure call. When an event is taken, three things happen. The instruction in flight is annulled. Its return address, the PC plus four, is written into a reserved general register, register 30. The PC is then loaded with a fixed low-memory vector that depends on the event class: 0x4 for synchronous events and 0x8 for asynchronous ones.

The unit owns the PC register. In normal flow it loads the sequential or branch target that the datapath proposes. PC bit 31 is a supervisor flag. Both vectors set it. Asynchronous requests are deferred while it is set, so a handler cannot be interrupted before it has saved register 30. A request that cannot be taken at once is held pending until it is taken.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted and after it is released, the PC reads 0x8000_0000. The annul and register-write outputs are 0 while no event is present.
- R2: With no fault and no request that can be taken, annul_o and rf_we_o are 0. On the next clock edge the PC takes the value on seq_pc_i.
- R3: A synchronous event (ill_op_i or sync_fault_i high) asserts annul_o in the same cycle, whatever the supervisor bit is.
- R4: Whenever an event is taken, rf_we_o is 1 and rf_wa_o is 30. rf_wd_o holds the current PC with bits 30:0 incremented by 4 and bit 31 unchanged.
- R5: A synchronous event loads the PC with 0x8000_0004 on the very next clock edge.
- R6: An interrupt request with PC bit 31 clear loads the PC with 0x8000_0008 on the next edge, and also annuls and writes register 30.
- R7: When a synchronous event and an interrupt request occur in the same cycle, the synchronous vector is taken and the request stays pending.
- R8: While PC bit 31 is 1 and no synchronous event is present, a request is not taken. annul_o stays 0 and the PC follows seq_pc_i.
- R9: A deferred request is taken in the first cycle with PC bit 31 clear, even after irq_i has dropped. Once taken, it is cleared and causes no second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_pc_i | input | 32 | PC proposed by the datapath for normal flow |
| ill_op_i | input | 1 | Decoder flags an illegal or unimplemented opcode |
| sync_fault_i | input | 1 | Other synchronous fault or trap |
| irq_i | input | 1 | Asynchronous interrupt request (level or pulse) |
| pc_o | output | 32 | Current PC; bit 31 is the supervisor flag |
| annul_o | output | 1 | Suppress register and memory writes of the current instruction |
| rf_we_o | output | 1 | Register-file write enable for the return address |
| rf_wa_o | output | 5 | Register-file write address (30 when writing) |
| rf_wd_o | output | 32 | Return address to save |

## Verification
Each fault source is driven alone from user mode, and an illegal opcode is also driven from supervisor mode. These runs separate the two synchronous inputs and show that the supervisor bit does not mask them. An interrupt is raised first in user mode and then together with a fault. This separates the two vectors and shows that the synchronous class wins while the request is kept. Requests that are held high, or that pulse while the supervisor bit is set, show that a deferred request is neither taken early nor lost. A following user-mode cycle shows that it is taken only once.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_SYNC  = 2'd1,
      EV_ASYNC = 2'd2
   } ev_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic     ill_op_i,
   input  logic     fault_i,
   input  logic     req_i,
   input  logic     sup_i,
   output ev_kind_e kind_o
);
   logic sync_hit;
   assign sync_hit = ill_op_i | fault_i;

   always_comb begin
      if (sync_hit)
         kind_o = EV_SYNC;
      else if (req_i && !sup_i)
         kind_o = EV_ASYNC;
      else
         kind_o = EV_NONE;
   end

   always_comb begin
      assert (!(sync_hit && kind_o != EV_SYNC))
         else $error("p_sync_first_r7");
      assert (!(sup_i && !sync_hit && kind_o != EV_NONE))
         else $error("p_sup_masks_r8");
   end
endmodule

// File: rtl/exc_irq_hold.sv
module exc_irq_hold #(
   parameter bit LATCH_REQ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_i,
   input  logic taken_i,
   output logic req_o
);
   generate
      if (LATCH_REQ) begin : g_latch
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_q <= 1'b0;
            else
               pend_q <= (pend_q | irq_i) & ~taken_i;
         end
         assign req_o = irq_i | pend_q;

         p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (taken_i && !irq_i) |=> !pend_q);
         p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_i && !taken_i) |=> pend_q);
      end else begin : g_level
         assign req_o = irq_i;
      end
   endgenerate
endmodule

// File: rtl/exc_pc_reg.sv
module exc_pc_reg
   import exc_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter logic [31:0] RESET_PC  = 32'h8000_0000,
   parameter logic [31:0] SYNC_VEC  = 32'h0000_0004,
   parameter logic [31:0] ASYNC_VEC = 32'h0000_0008
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ev_kind_e        kind_i,
   input  logic [XLEN-1:0] seq_pc_i,
   output logic [XLEN-1:0] pc_o
);
   localparam int SUP = XLEN - 1;

   logic [XLEN-1:0] pc_q, pc_d;
   logic [XLEN-1:0] sync_tgt, async_tgt;

   assign sync_tgt  = {1'b1, SYNC_VEC[SUP-1:0]};
   assign async_tgt = {1'b1, ASYNC_VEC[SUP-1:0]};

   always_comb begin
      unique case (kind_i)
         EV_SYNC:  pc_d = sync_tgt;
         EV_ASYNC: pc_d = async_tgt;
         default:  pc_d = seq_pc_i;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc_q <= RESET_PC[XLEN-1:0];
      else
         pc_q <= pc_d;
   end
   assign pc_o = pc_q;

   p_vec_sets_sup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i != EV_NONE) |=> pc_q[SUP]);
   p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == EV_NONE) |=> pc_q == $past(seq_pc_i));
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          REG_AW    = 5,
   parameter int          XP_IDX    = 30,
   parameter logic [31:0] RESET_PC  = 32'h8000_0000,
   parameter logic [31:0] SYNC_VEC  = 32'h0000_0004,
   parameter logic [31:0] ASYNC_VEC = 32'h0000_0008,
   parameter bit          LATCH_REQ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   seq_pc_i,
   input  logic              ill_op_i,
   input  logic              sync_fault_i,
   input  logic              irq_i,
   output logic [XLEN-1:0]   pc_o,
   output logic              annul_o,
   output logic              rf_we_o,
   output logic [REG_AW-1:0] rf_wa_o,
   output logic [XLEN-1:0]   rf_wd_o
);
   localparam int          SUP     = XLEN - 1;
   localparam int          NREGS   = 1 << REG_AW;
   localparam logic [SUP-1:0] STEP = SUP'(4);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("exc_entry_unit: XLEN must be 32");
      end
      if (XP_IDX >= NREGS - 1 || XP_IDX < 1) begin : g_bad_xp
         $error("exc_entry_unit: XP_IDX must name a writable register");
      end
      if (SYNC_VEC[1:0] != 2'b00 || ASYNC_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("exc_entry_unit: vectors must be word aligned");
      end
      if (SYNC_VEC == ASYNC_VEC) begin : g_same_vec
         $error("exc_entry_unit: vectors must differ");
      end
   endgenerate

   ev_kind_e kind;
   logic     req;
   logic     taken;

   exc_irq_hold #(.LATCH_REQ(LATCH_REQ)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_i   (irq_i),
      .taken_i (kind == EV_ASYNC),
      .req_o   (req)
   );

   exc_arbiter u_arb (
      .ill_op_i (ill_op_i),
      .fault_i  (sync_fault_i),
      .req_i    (req),
      .sup_i    (pc_o[SUP]),
      .kind_o   (kind)
   );

   exc_pc_reg #(
      .XLEN      (XLEN),
      .RESET_PC  (RESET_PC),
      .SYNC_VEC  (SYNC_VEC),
      .ASYNC_VEC (ASYNC_VEC)
   ) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .seq_pc_i (seq_pc_i),
      .pc_o     (pc_o)
   );

   assign taken   = (kind != EV_NONE);
   assign annul_o = taken;
   assign rf_we_o = taken;
   assign rf_wa_o = REG_AW'(XP_IDX);
   assign rf_wd_o = {pc_o[SUP], pc_o[SUP-1:0] + STEP};

   p_sync_annul_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_op_i || sync_fault_i) |-> annul_o);
   p_sync_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_op_i || sync_fault_i) |=> pc_o == {1'b1, SYNC_VEC[SUP-1:0]});
   p_async_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (annul_o && !ill_op_i && !sync_fault_i) |=> pc_o == {1'b1, ASYNC_VEC[SUP-1:0]});
   p_sup_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_o[SUP] && !ill_op_i && !sync_fault_i) |-> !annul_o);
   p_ret_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (rf_wa_o == REG_AW'(XP_IDX) && rf_wd_o[SUP] == pc_o[SUP]));
endmodule

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/100ps
module exc_entry_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] seq_pc;
   logic        ill_op, fault, irq;
   logic [31:0] pc;
   logic        annul, we;
   logic [4:0]  wa;
   logic [31:0] wd;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   exc_entry_unit u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .seq_pc_i     (seq_pc),
      .ill_op_i     (ill_op),
      .sync_fault_i (fault),
      .irq_i        (irq),
      .pc_o         (pc),
      .annul_o      (annul),
      .rf_we_o      (we),
      .rf_wa_o      (wa),
      .rf_wd_o      (wd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at negedge, check same-cycle outputs, then PC after the edge
   task automatic step(input logic [31:0] nxt, input logic i, input logic f,
                       input logic q, input string tag, input logic exp_take,
                       input logic [31:0] exp_wd, input logic [31:0] exp_pc);
      @(negedge clk);
      seq_pc = nxt; ill_op = i; fault = f; irq = q;
      #1;
      chk({tag, " annul"}, {31'd0, annul}, {31'd0, exp_take});
      chk({tag, " we"}, {31'd0, we}, {31'd0, exp_take});
      if (exp_take) begin
         chk({tag, " wa R4"}, {27'd0, wa}, 32'd30);
         chk({tag, " wd R4"}, wd, exp_wd);
      end
      @(posedge clk); #1;
      chk({tag, " pc"}, pc, exp_pc);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; seq_pc = 32'h0; ill_op = 0; fault = 0; irq = 0;
      repeat (3) @(posedge clk);
      #1 chk("R1 pc in reset", pc, 32'h8000_0000);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 pc after reset", pc, 32'h8000_0000);
      chk("R1 annul", {31'd0, annul}, 32'd0);
      chk("R1 we", {31'd0, we}, 32'd0);
   endtask

   task automatic t_normal();
      step(32'h100, 0, 0, 0, "R2 flow a", 0, 0, 32'h100);
      step(32'h104, 0, 0, 0, "R2 flow b", 0, 0, 32'h104);
   endtask

   task automatic t_sync();
      step(32'h108, 1, 0, 0, "R3 R5 illop", 1, 32'h108, 32'h8000_0004);
      step(32'h200, 0, 0, 0, "R2 return", 0, 0, 32'h200);
      step(32'h208, 0, 1, 0, "R3 R5 fault", 1, 32'h204, 32'h8000_0004);
      step(32'h8000_0010, 1, 0, 0, "R3 sup illop", 1, 32'h8000_0008, 32'h8000_0004);
   endtask

   task automatic t_async();
      step(32'h300, 0, 0, 0, "R2 to user", 0, 0, 32'h300);
      step(32'h304, 0, 0, 1, "R6 irq", 1, 32'h304, 32'h8000_0008);
      step(32'h8000_0010, 0, 0, 0, "R9 no repeat sup", 0, 0, 32'h8000_0010);
      step(32'h304, 0, 0, 0, "R9 resume", 0, 0, 32'h304);
      step(32'h308, 0, 0, 0, "R9 cleared", 0, 0, 32'h308);
   endtask

   task automatic t_collide();
      step(32'h30C, 1, 0, 1, "R7 both", 1, 32'h30C, 32'h8000_0004);
      step(32'h8000_0010, 0, 0, 0, "R8 pending held", 0, 0, 32'h8000_0010);
      step(32'h400, 0, 0, 0, "R8 sup return", 0, 0, 32'h400);
      step(32'h404, 0, 0, 0, "R7 pending taken", 1, 32'h404, 32'h8000_0008);
   endtask

   task automatic t_blocked();
      step(32'h8000_0020, 0, 0, 1, "R8 level a", 0, 0, 32'h8000_0020);
      step(32'h8000_0024, 0, 0, 1, "R8 level b", 0, 0, 32'h8000_0024);
      step(32'h500, 0, 0, 0, "R8 drop", 0, 0, 32'h500);
      step(32'h504, 0, 0, 0, "R9 late take", 1, 32'h504, 32'h8000_0008);
      step(32'h600, 0, 0, 0, "R2 back", 0, 0, 32'h600);
      step(32'h604, 0, 0, 0, "R9 once", 0, 0, 32'h604);
   endtask

   initial begin : watchdog
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_normal();
      t_sync();
      t_async();
      t_collide();
      t_blocked();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule